// File: doc/BRIEF.md
# Radio transceiver state controller

This block holds the operating state of a packet radio. A host writes 5-bit state-change commands into a command field. A single multi-purpose pin puts the radio to sleep or starts a transmission, depending on the state the radio is in. The receive and transmit datapath reports frame start and frame end. From these inputs the controller moves through power-on, off, sleep, synthesizer-on, listening, busy-receive and busy-transmit states. It drives enables for the receiver, the transmitter and the frequency synthesizer.

The status output always shows the state the controller has actually reached. While the synthesizer is settling, status shows a transitional code. Analog settling is modelled with cycle counters whose lengths are parameters. A normal off command that arrives during a frame is held until the frame is over. A forced off command ends the frame at once. Each completed transmission raises a one-cycle event.

Top module: `radio_state_ctrl`

## Requirements
- R1: While `por_n` is low, `status` is 0 (power-on), `cmd_field` is 0 and all enables are low. After `por_n` is released, `status` stays 0 for exactly POR_CYC clock edges and then reads 8 (off). Commands written during power-on do not change the state.
- R2: Commands are decoded on `cmd` when `cmd_we` is high: 2 transmit-start, 3 forced-off, 6 receive, 8 off, 9 synthesizer-on, 22 auto-acknowledge receive, 25 auto-retry transmit. Every other code changes nothing. `cmd_field` returns the last written code.
- R3: From off (8), a command of 6, 9, 22 or 25 shows status 31 for exactly SETTLE_CYC cycles, then the matching state code (6, 9, 22 or 25). A command of 8 or 3 during settling returns the controller to 8 at once.
- R4: Receive is split into a listening state and a busy state. Frame start in 6 gives 1, and frame end in 1 returns to 6. Frame start in 22 gives 17, and frame end in 17 returns to 22.
- R5: Command 3 in any busy state (1, 2, 17, 18) gives status 8 on the next cycle and raises no transmit event.
- R6: Command 8 in a busy state is held. The state stays busy until frame end, and then goes to 8.
- R7: In 8, `mode_pin` high gives sleep (15). In 15, commands are ignored, and `mode_pin` low returns the controller to 8.
- R8: In 9, a rising edge on `mode_pin` or command 2 gives busy transmit (2). In 25, either one gives 18.
- R9: Frame end in 2 returns to 9, and frame end in 18 returns to 25. In both cases `tx_done` is high for exactly one cycle.
- R10: With `rst_n` low, the next state is 8 from every state except power-on. Power-on ignores `rst_n`.
- R11: `rx_en` is high in 6, 22, 1 and 17. `tx_en` is high in 2 and 18. `pll_en` is high in those states and in 9, 25 and 31. All three are low in 0, 8 and 15.
- R12: Switching among 6, 9, 22 and 25 by command takes effect on the next cycle, without a settling phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_n | input | 1 | Synchronous reset to off, active low |
| cmd_we | input | 1 | Command write strobe |
| cmd | input | 5 | Command code |
| mode_pin | input | 1 | Sleep / transmit-start pin |
| frame_start | input | 1 | Frame start indication from datapath |
| frame_end | input | 1 | Frame end indication from datapath |
| status | output | 5 | Current state code |
| cmd_field | output | 5 | Last written command |
| rx_en | output | 1 | Receiver enable |
| tx_en | output | 1 | Transmitter enable |
| pll_en | output | 1 | Synthesizer enable |
| tx_done | output | 1 | One-cycle transmission-complete event |

## Verification
The directed scenarios cover several distinct stimulus patterns:
- An off command in the middle of a frame tells deferred handling apart from immediate handling.
- The same busy-receive situation is then ended by a forced off, which tells aborting apart from waiting.
- The pin is driven as a level in off and sleep, and as a rising edge in synthesizer-on. This separates its two meanings.
- An undefined code is written, to show that decoding rejects it.
- Transmit is entered by pin and by command, from both plain and auto-retry states, to confirm the return target and the one-cycle event.
- The reset input is applied both during power-on and after it, which separates the two resets.

// File: rtl/radio_state_ctrl.sv
module radio_state_ctrl #(
  parameter int SETTLE_CYC = 12,
  parameter int POR_CYC    = 20
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       rst_n,
  input  logic       cmd_we,
  input  logic [4:0] cmd,
  input  logic       mode_pin,
  input  logic       frame_start,
  input  logic       frame_end,
  output logic [4:0] status,
  output logic [4:0] cmd_field,
  output logic       rx_en,
  output logic       tx_en,
  output logic       pll_en,
  output logic       tx_done
);

  localparam int MAXC = (SETTLE_CYC > POR_CYC) ? SETTLE_CYC : POR_CYC;
  localparam int CW   = (MAXC < 2) ? 1 : $clog2(MAXC + 1);

  typedef enum logic [4:0] {
    S_PON   = 5'd0,
    S_BRX   = 5'd1,
    S_BTX   = 5'd2,
    S_RXON  = 5'd6,
    S_OFF   = 5'd8,
    S_PLL   = 5'd9,
    S_SLEEP = 5'd15,
    S_BRXA  = 5'd17,
    S_BTXA  = 5'd18,
    S_RXA   = 5'd22,
    S_TXA   = 5'd25,
    S_TRANS = 5'd31
  } st_t;

  st_t st, st_nx, tgt, tgt_nx;
  logic [CW-1:0] cnt, cnt_nx;
  logic pend, pend_nx, pin_q, done_nx;

  wire c_txs   = cmd_we && (cmd == 5'd2);
  wire c_force = cmd_we && (cmd == 5'd3);
  wire c_rx    = cmd_we && (cmd == 5'd6);
  wire c_off   = cmd_we && (cmd == 5'd8);
  wire c_pll   = cmd_we && (cmd == 5'd9);
  wire c_aack  = cmd_we && (cmd == 5'd22);
  wire c_aret  = cmd_we && (cmd == 5'd25);
  wire c_on    = c_rx | c_pll | c_aack | c_aret;
  wire pin_rise = mode_pin && !pin_q;
  wire tx_go    = c_txs || pin_rise;

  function automatic st_t on_target(logic rx, logic pll, logic aack);
    if (rx)        return S_RXON;
    else if (pll)  return S_PLL;
    else if (aack) return S_RXA;
    else           return S_TXA;
  endfunction

  always_comb begin
    st_nx   = st;
    tgt_nx  = tgt;
    cnt_nx  = cnt;
    pend_nx = pend;
    done_nx = 1'b0;
    case (st)
      S_PON: begin
        if (cnt == '0) st_nx = S_OFF;
        else           cnt_nx = cnt - CW'(1);
      end
      S_OFF: begin
        if (c_on) begin
          st_nx  = S_TRANS;
          tgt_nx = on_target(c_rx, c_pll, c_aack);
          cnt_nx = CW'(SETTLE_CYC - 1);
        end else if (mode_pin) begin
          st_nx = S_SLEEP;
        end
      end
      S_SLEEP: if (!mode_pin) st_nx = S_OFF;
      S_TRANS: begin
        if (c_off || c_force) st_nx = S_OFF;
        else if (cnt == '0)   st_nx = tgt;
        else                  cnt_nx = cnt - CW'(1);
      end
      S_PLL, S_RXON, S_RXA, S_TXA: begin
        if (c_off || c_force) st_nx = S_OFF;
        else if (c_on)        st_nx = on_target(c_rx, c_pll, c_aack);
        else if (st == S_PLL  && tx_go)       st_nx = S_BTX;
        else if (st == S_TXA  && tx_go)       st_nx = S_BTXA;
        else if (st == S_RXON && frame_start) st_nx = S_BRX;
        else if (st == S_RXA  && frame_start) st_nx = S_BRXA;
      end
      S_BRX, S_BTX, S_BRXA, S_BTXA: begin
        if (c_force) begin
          st_nx   = S_OFF;
          pend_nx = 1'b0;
        end else if (frame_end) begin
          pend_nx = 1'b0;
          done_nx = (st == S_BTX) || (st == S_BTXA);
          if (pend || c_off)     st_nx = S_OFF;
          else if (st == S_BRX)  st_nx = S_RXON;
          else if (st == S_BTX)  st_nx = S_PLL;
          else if (st == S_BRXA) st_nx = S_RXA;
          else                   st_nx = S_TXA;
        end else if (c_off) begin
          pend_nx = 1'b1;
        end
      end
      default: st_nx = S_OFF;
    endcase
    if (!rst_n && st != S_PON) begin
      st_nx   = S_OFF;
      pend_nx = 1'b0;
      done_nx = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st        <= S_PON;
      tgt       <= S_OFF;
      cnt       <= CW'(POR_CYC - 1);
      pend      <= 1'b0;
      pin_q     <= 1'b0;
      tx_done   <= 1'b0;
      cmd_field <= 5'd0;
    end else begin
      st      <= st_nx;
      tgt     <= tgt_nx;
      cnt     <= cnt_nx;
      pend    <= pend_nx;
      pin_q   <= mode_pin;
      tx_done <= done_nx;
      if (!rst_n)      cmd_field <= 5'd0;
      else if (cmd_we) cmd_field <= cmd;
    end
  end

  assign status = st;
  assign rx_en  = st inside {S_RXON, S_RXA, S_BRX, S_BRXA};
  assign tx_en  = st inside {S_BTX, S_BTXA};
  assign pll_en = rx_en || tx_en || (st inside {S_PLL, S_TXA, S_TRANS});

endmodule

// File: rtl/radio_state_ctrl_chk.sv
module radio_state_ctrl_chk (
  input logic       clk,
  input logic       por_n,
  input logic       rst_n,
  input logic       cmd_we,
  input logic [4:0] cmd,
  input logic       mode_pin,
  input logic       frame_end,
  input logic [4:0] status,
  input logic       rx_en,
  input logic       tx_en,
  input logic       pll_en,
  input logic       tx_done
);

  AST_RST_TO_OFF: assert property (@(posedge clk) disable iff (!por_n)
    (!rst_n && status != 5'd0) |=> status == 5'd8); // R10
  AST_FORCE_ABORT: assert property (@(posedge clk) disable iff (!por_n)
    (cmd_we && cmd == 5'd3 && status inside {5'd1, 5'd2, 5'd17, 5'd18}) |=> status == 5'd8); // R5
  AST_BUSY_RX_HOLD: assert property (@(posedge clk) disable iff (!por_n)
    (rst_n && status == 5'd1 && !frame_end && !(cmd_we && cmd == 5'd3)) |=> status == 5'd1); // R6
  AST_DONE_AFTER_TX: assert property (@(posedge clk) disable iff (!por_n)
    tx_done |-> ($past(status) == 5'd2 || $past(status) == 5'd18)); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!por_n)
    tx_done |=> !tx_done); // R9
  AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!por_n)
    (rst_n && status == 5'd15 && mode_pin) |=> status == 5'd15); // R7
  AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!por_n)
    (status == 5'd15) |-> !(rx_en || tx_en || pll_en)); // R11
  AST_RX_TX_EXCL: assert property (@(posedge clk) disable iff (!por_n)
    !(rx_en && tx_en)); // R11

endmodule

bind radio_state_ctrl radio_state_ctrl_chk u_chk (
  .clk(clk), .por_n(por_n), .rst_n(rst_n), .cmd_we(cmd_we), .cmd(cmd),
  .mode_pin(mode_pin), .frame_end(frame_end), .status(status),
  .rx_en(rx_en), .tx_en(tx_en), .pll_en(pll_en), .tx_done(tx_done)
);

// File: tb/radio_state_ctrl_tb.sv
`timescale 1ns/1ps
module radio_state_ctrl_tb;
  localparam int SC = 4;
  localparam int PC = 6;

  logic clk = 1'b0;
  logic por_n = 1'b0, rst_n = 1'b1, cmd_we = 1'b0, mode_pin = 1'b0;
  logic frame_start = 1'b0, frame_end = 1'b0;
  logic [4:0] cmd = 5'd0;
  logic [4:0] status, cmd_field;
  logic rx_en, tx_en, pll_en, tx_done;
  int total = 0, fails = 0, cyc = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  radio_state_ctrl #(.SETTLE_CYC(SC), .POR_CYC(PC)) u_dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .cmd_we(cmd_we), .cmd(cmd),
    .mode_pin(mode_pin), .frame_start(frame_start), .frame_end(frame_end),
    .status(status), .cmd_field(cmd_field), .rx_en(rx_en), .tx_en(tx_en),
    .pll_en(pll_en), .tx_done(tx_done));

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      finished = 1'b1;
      total++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 20000", cyc);
      summary();
    end
  end

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_cmd(logic [4:0] c);
    cmd = c; cmd_we = 1'b1; step(); cmd_we = 1'b0;
  endtask

  task automatic pulse_start(); frame_start = 1'b1; step(); frame_start = 1'b0; endtask
  task automatic pulse_end();   frame_end = 1'b1;   step(); frame_end = 1'b0;   endtask

  task automatic settle_to(logic [4:0] c, string req);
    do_cmd(c);
    chk({req, " transitional code"}, status, 31);
    chk("R11 pll_en while settling", pll_en, 1);
    step(SC - 1);
    chk({req, " still settling at window end"}, status, 31);
    step();
    chk({req, " settled target"}, status, c);
  endtask

  task automatic t_power_on();
    por_n = 1'b0; step();
    chk("R1 status in power-on", status, 0);
    chk("R1 cmd_field reset", cmd_field, 0);
    chk("R11 enables low in power-on", {rx_en, tx_en, pll_en}, 0);
    por_n = 1'b1;
    do_cmd(5'd6);
    step(PC - 2);
    chk("R1 power-on held, command ignored", status, 0);
    chk("R2 cmd_field readback", cmd_field, 6);
    step();
    chk("R1 power-on ends in off", status, 8);
  endtask

  task automatic t_sleep();
    mode_pin = 1'b1; step();
    chk("R7 pin high in off gives sleep", status, 15);
    chk("R11 enables low in sleep", {rx_en, tx_en, pll_en}, 0);
    do_cmd(5'd6);
    chk("R7 command ignored in sleep", status, 15);
    mode_pin = 1'b0; step();
    chk("R7 pin low wakes to off", status, 8);
  endtask

  task automatic t_receive();
    settle_to(5'd6, "R3 receive");
    chk("R11 rx_en in listen", rx_en, 1);
    do_cmd(5'd7);
    chk("R2 undefined code ignored", status, 6);
    pulse_start();
    chk("R4 frame start gives busy receive", status, 1);
    pulse_end();
    chk("R4 frame end returns to listen", status, 6);
  endtask

  task automatic t_deferred_off();
    pulse_start();
    do_cmd(5'd8);
    chk("R6 off held during frame", status, 1);
    step(3);
    chk("R6 still busy before frame end", status, 1);
    pulse_end();
    chk("R6 off taken after frame end", status, 8);
  endtask

  task automatic t_forced_off_rx();
    do_cmd(5'd6);
    do_cmd(5'd3);
    chk("R3 forced off during settling", status, 8);
    settle_to(5'd6, "R3 receive again");
    pulse_start();
    do_cmd(5'd3);
    chk("R5 forced off aborts receive", status, 8);
    chk("R11 rx_en low after abort", rx_en, 0);
  endtask

  task automatic t_transmit();
    settle_to(5'd9, "R3 synthesizer");
    chk("R11 synthesizer only", {rx_en, tx_en, pll_en}, 1);
    mode_pin = 1'b1; step();
    chk("R8 pin edge starts transmit", status, 2);
    chk("R11 tx_en in busy transmit", tx_en, 1);
    mode_pin = 1'b0;
    pulse_end();
    chk("R9 return to synthesizer-on", status, 9);
    chk("R9 tx_done raised", tx_done, 1);
    step();
    chk("R9 tx_done one cycle", tx_done, 0);
    do_cmd(5'd2);
    chk("R8 command starts transmit", status, 2);
    do_cmd(5'd3);
    chk("R5 forced off aborts transmit", status, 8);
    chk("R5 no event on abort", tx_done, 0);
  endtask

  task automatic t_modes();
    settle_to(5'd9, "R3 synthesizer");
    do_cmd(5'd6);
    chk("R12 direct switch to receive", status, 6);
    do_cmd(5'd25);
    chk("R12 direct switch to auto-retry", status, 25);
    do_cmd(5'd2);
    chk("R8 auto-retry busy transmit", status, 18);
    pulse_end();
    chk("R9 return to auto-retry", status, 25);
    chk("R9 tx_done after auto-retry", tx_done, 1);
    do_cmd(5'd22);
    chk("R12 direct switch to auto-ack", status, 22);
    pulse_start();
    chk("R4 auto-ack busy receive", status, 17);
    pulse_end();
    chk("R4 back to auto-ack listen", status, 22);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; step(); rst_n = 1'b1;
    chk("R10 reset from auto-ack listen", status, 8);
    chk("R10 cmd_field cleared", cmd_field, 0);
    por_n = 1'b0; step(); por_n = 1'b1;
    rst_n = 1'b0; step(3);
    chk("R10 reset ignored in power-on", status, 0);
    rst_n = 1'b1;
    step(PC - 3);
    chk("R10 power-on completes normally", status, 8);
  endtask

  initial begin
    t_power_on();
    t_sleep();
    t_receive();
    t_deferred_off();
    t_forced_off_rx();
    t_transmit();
    t_modes();
    t_reset();
    finished = 1'b1;
    summary();
  end
endmodule